// File: doc/BRIEF.md
# Path Trace Message Buffer

This block carries a 64-byte path trace message, one byte per frame, in both directions. On the transmit side it steps through a software-written 64-byte transmit buffer. Each frame strobe sends the next byte, and after the last byte it returns to the first. On the receive side it takes the trace byte that arrives with each frame strobe and places it by a free-running frame position counter. It accepts a message into the receive buffer only when the same 64 bytes have arrived in three consecutive complete messages.

A single-cycle change pulse marks an accepted message that differs from the buffer's previous contents. A byte that flickers for one message resets the integration, so it produces neither an update nor a pulse. Five upstream defect inputs freeze the receive side while any of them is active. The defects are loss of signal, loss of frame, line AIS, path AIS and loss of pointer. The transmit side keeps running regardless of them. Both buffers can be read combinationally through one shared address. The transmit buffer is written through a simple write port.

Top module: `path_trace_buf`

## Requirements
- R1: After reset the receive and transmit buffers read all zero, the change pulse is low, and the transmit byte and frame position counters are both at position 0.
- R2: While `tx_en` is 1, `tx_byte` shows transmit buffer entry at the transmit index. Each `frame_stb` advances that index by one, and it wraps from 63 to 0.
- R3: While `tx_en` is 0, `tx_byte` is 0x00 and frame strobes do not move the transmit index. Sending resumes from the held index.
- R4: The transmit stream does not depend on the defect inputs.
- R5: A cycle with `wr_en` high writes `wr_data` into transmit buffer entry `wr_addr`. It is readable on `tx_rd_data` from the next cycle.
- R6: The receive byte of the k-th frame strobe after reset belongs to message position (k-1) mod 64.
- R7: A received message is copied into the receive buffer on the strobe of byte 63 of its third consecutive identical arrival. It is readable on `rx_rd_data` from the next cycle.
- R8: `trace_chg` pulses high for exactly one cycle after the acceptance edge, and only if the accepted message differs from the previous receive buffer contents.
- R9: A message that differs in any byte from the message before it restarts the integration with a count of one. A single altered message therefore causes no acceptance and no pulse.
- R10: While any `defect` bit is 1, the receive buffer is unchanged and no pulse occurs. After all defects clear, three further complete messages must arrive without a defect before acceptance. A message during which a defect was present never counts.
- R11: Once a message is accepted, further identical messages neither rewrite the buffer nor pulse. A message re-accepted after a broken integration that equals the buffer gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_stb | input | 1 | One-cycle strobe per frame |
| rx_byte | input | 8 | Received trace byte, valid with `frame_stb` |
| defect | input | 5 | Upstream defects: bit0 signal loss, bit1 frame loss, bit2 line AIS, bit3 path AIS, bit4 pointer loss |
| tx_en | input | 1 | Transmit enable |
| tx_byte | output | 8 | Trace byte to send in the current frame |
| wr_en | input | 1 | Transmit buffer write enable |
| wr_addr | input | 6 | Transmit buffer write position |
| wr_data | input | 8 | Transmit buffer write data |
| rd_addr | input | 6 | Read position for both buffers |
| rx_rd_data | output | 8 | Receive buffer entry at `rd_addr` |
| tx_rd_data | output | 8 | Transmit buffer entry at `rd_addr` |
| trace_chg | output | 1 | One-cycle pulse when a new, different message is accepted |

## Verification
A wrong repeat count or a stale mismatch flag shows at the port at the end of the message in which it occurs. The symptoms are a `trace_chg` pulse or a receive buffer change one message (64 frames) too early or too late, or missing altogether. A slipped frame position counter corrupts the receive buffer contents read back byte by byte. A slipped transmit index shows on `tx_byte` at the very next frame. The stimulus therefore checks the pulse and the full receive buffer after every message. It compares every transmitted byte against a model of the transmit index.

// File: rtl/path_trace_buf.sv
module path_trace_buf #(
  parameter int MSG_LEN = 64,
  parameter int BW      = 8,
  parameter int REPEATS = 3,
  parameter int NDEF    = 5,
  localparam int IW     = $clog2(MSG_LEN),
  localparam int CW     = $clog2(REPEATS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_stb,
  input  logic [BW-1:0]   rx_byte,
  input  logic [NDEF-1:0] defect,
  input  logic            tx_en,
  output logic [BW-1:0]   tx_byte,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_addr,
  input  logic [BW-1:0]   wr_data,
  input  logic [IW-1:0]   rd_addr,
  output logic [BW-1:0]   rx_rd_data,
  output logic [BW-1:0]   tx_rd_data,
  output logic            trace_chg
);
  localparam logic [IW-1:0] LAST = IW'(MSG_LEN - 1);

  logic [BW-1:0] tx_mem  [MSG_LEN];
  logic [BW-1:0] cap_mem [MSG_LEN];
  logic [BW-1:0] rx_mem  [MSG_LEN];
  logic [BW-1:0] nxt_msg [MSG_LEN];
  logic [IW-1:0] tx_idx, rx_idx;
  logic [CW-1:0] rep_cnt, cnt_nx;
  logic          mm, dirty, differs, accept;

  wire any_def = |defect;
  wire at_last = (rx_idx == LAST);
  wire byte_mm = (rx_byte != cap_mem[rx_idx]);
  wire msg_mm  = (rx_idx == '0) ? byte_mm : (mm | byte_mm);

  assign tx_byte    = tx_en ? tx_mem[tx_idx] : '0;
  assign rx_rd_data = rx_mem[rd_addr];
  assign tx_rd_data = tx_mem[rd_addr];

  for (genvar g = 0; g < MSG_LEN; g++) begin : g_nxt
    assign nxt_msg[g] = (g == MSG_LEN - 1) ? rx_byte : cap_mem[g];
  end

  always_comb begin
    cnt_nx = rep_cnt;
    if (any_def)
      cnt_nx = '0;
    else if (frame_stb && at_last) begin
      if (dirty)
        cnt_nx = '0;
      else if (rep_cnt == '0 || msg_mm)
        cnt_nx = CW'(1);
      else if (rep_cnt < CW'(REPEATS))
        cnt_nx = CW'(rep_cnt + 1'b1);
    end
  end

  assign accept = frame_stb && at_last && (cnt_nx == CW'(REPEATS))
                  && (rep_cnt != CW'(REPEATS));

  always_comb begin
    differs = 1'b0;
    for (int k = 0; k < MSG_LEN; k++)
      if (nxt_msg[k] != rx_mem[k]) differs = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_idx    <= '0;
      rx_idx    <= '0;
      rep_cnt   <= '0;
      mm        <= 1'b0;
      dirty     <= 1'b0;
      trace_chg <= 1'b0;
      for (int k = 0; k < MSG_LEN; k++) begin
        tx_mem[k]  <= '0;
        cap_mem[k] <= '0;
        rx_mem[k]  <= '0;
      end
    end else begin
      rep_cnt   <= cnt_nx;
      trace_chg <= accept && differs;
      if (wr_en)
        tx_mem[wr_addr] <= wr_data;
      if (frame_stb && tx_en)
        tx_idx <= (tx_idx == LAST) ? '0 : tx_idx + 1'b1;
      if (frame_stb)
        rx_idx <= at_last ? '0 : rx_idx + 1'b1;
      if (frame_stb && at_last)
        dirty <= 1'b0;
      else if (any_def)
        dirty <= 1'b1;
      if (frame_stb && !any_def) begin
        cap_mem[rx_idx] <= rx_byte;
        mm <= at_last ? 1'b0 : msg_mm;
      end
      if (accept)
        for (int k = 0; k < MSG_LEN; k++)
          rx_mem[k] <= nxt_msg[k];
    end
  end
endmodule

// File: rtl/path_trace_buf_chk.sv
module path_trace_buf_chk #(
  parameter int MSG_LEN = 64,
  parameter int REPEATS = 3,
  parameter int NDEF    = 5,
  localparam int IW     = $clog2(MSG_LEN),
  localparam int CW     = $clog2(REPEATS + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frame_stb,
  input logic            tx_en,
  input logic [NDEF-1:0] defect,
  input logic            trace_chg,
  input logic [IW-1:0]   tx_idx,
  input logic [CW-1:0]   rep_cnt
);
  AST_CHG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    trace_chg |=> !trace_chg); // R8
  AST_CHG_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    trace_chg |-> $past(frame_stb)); // R7
  AST_CHG_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    trace_chg |-> (rep_cnt == CW'(REPEATS))); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rep_cnt <= CW'(REPEATS)); // R9
  AST_DEF_NO_CHG: assert property (@(posedge clk) disable iff (!rst_n)
    (|defect) |=> (!trace_chg && rep_cnt == '0)); // R10
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> $stable(tx_idx)); // R3
  AST_TX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && tx_en && tx_idx == IW'(MSG_LEN - 1)) |=> (tx_idx == '0)); // R2
  AST_TX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && tx_en && tx_idx != IW'(MSG_LEN - 1)) |=>
      (tx_idx == IW'($past(tx_idx) + 1'b1))); // R2
endmodule

bind path_trace_buf path_trace_buf_chk #(
  .MSG_LEN(MSG_LEN), .REPEATS(REPEATS), .NDEF(NDEF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .tx_en(tx_en),
  .defect(defect), .trace_chg(trace_chg), .tx_idx(tx_idx), .rep_cnt(rep_cnt)
);

// File: tb/sim_path_trace_buf.sv
`timescale 1ns/1ps
module sim_path_trace_buf;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       frame_stb = 1'b0, tx_en = 1'b1, wr_en = 1'b0, trace_chg;
  logic [7:0] rx_byte = '0, wr_data = '0, tx_byte, rx_rd_data, tx_rd_data;
  logic [4:0] defect = '0;
  logic [5:0] wr_addr = '0, rd_addr = '0;
  int n_chk = 0, n_bad = 0, tidx = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  path_trace_buf u0 (.clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_byte(rx_byte),
    .defect(defect), .tx_en(tx_en), .tx_byte(tx_byte), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rx_rd_data(rx_rd_data),
    .tx_rd_data(tx_rd_data), .trace_chg(trace_chg));

  // entry: seed[23:16] flip[15] defect[14:10] exp_pulse[9] exp_rx_seed[8:1] exp_rx_flip[0]
  localparam logic [23:0] TBL [20] = '{
    {8'd1, 1'b0, 5'd0,     1'b0, 8'd0, 1'b0},  // R9 first A
    {8'd1, 1'b0, 5'd0,     1'b0, 8'd0, 1'b0},
    {8'd1, 1'b0, 5'd0,     1'b1, 8'd1, 1'b0},  // R7 third A accepted
    {8'd1, 1'b0, 5'd0,     1'b0, 8'd1, 1'b0},  // R11
    {8'd2, 1'b0, 5'd0,     1'b0, 8'd1, 1'b0},
    {8'd2, 1'b0, 5'd0,     1'b0, 8'd1, 1'b0},
    {8'd2, 1'b1, 5'd0,     1'b0, 8'd1, 1'b0},  // R9 one byte altered
    {8'd2, 1'b0, 5'd0,     1'b0, 8'd1, 1'b0},
    {8'd2, 1'b0, 5'd0,     1'b0, 8'd1, 1'b0},
    {8'd2, 1'b0, 5'd0,     1'b1, 8'd2, 1'b0},
    {8'd3, 1'b0, 5'b00001, 1'b0, 8'd2, 1'b0},  // R10 signal loss
    {8'd3, 1'b0, 5'b00100, 1'b0, 8'd2, 1'b0},  // R10 line AIS
    {8'd3, 1'b0, 5'b10000, 1'b0, 8'd2, 1'b0},  // R10 pointer loss
    {8'd3, 1'b0, 5'd0,     1'b0, 8'd2, 1'b0},
    {8'd3, 1'b0, 5'd0,     1'b0, 8'd2, 1'b0},
    {8'd3, 1'b0, 5'd0,     1'b1, 8'd3, 1'b0},
    {8'd3, 1'b1, 5'd0,     1'b0, 8'd3, 1'b0},
    {8'd3, 1'b0, 5'd0,     1'b0, 8'd3, 1'b0},
    {8'd3, 1'b0, 5'd0,     1'b0, 8'd3, 1'b0},
    {8'd3, 1'b0, 5'd0,     1'b0, 8'd3, 1'b0}   // R11 re-accepted, equal
  };

  function automatic logic [7:0] mb(input int seed, input bit flip, input int i);
    logic [7:0] v;
    if (seed == 0) return 8'h00;
    v = 8'(seed * 29 + i * 3 + 1);
    if (flip && i == 17) v ^= 8'h5A;
    return v;
  endfunction

  function automatic logic [7:0] tx_pat(input int i);
    return 8'(i * 11 + 5);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_msg(input int seed, input bit flip, input logic [4:0] dv,
                          input int dlo, input int dhi, input int txon,
                          output bit pl, output bit po, output int txbad);
    pl = 0; po = 0; txbad = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      frame_stb = 1'b1;
      rx_byte = mb(seed, flip, i);
      defect = (i >= dlo && i <= dhi) ? dv : 5'd0;
      tx_en = (i >= txon);
      #1;
      if (tx_byte !== (tx_en ? tx_pat(tidx) : 8'h00)) txbad++;
      if (tx_en) tidx = (tidx + 1) % 64;
      @(posedge clk); #1;
      if (i == 63) pl = trace_chg;
      else if (trace_chg) po = 1;
      @(negedge clk);
      frame_stb = 1'b0;
      defect = '0;
    end
  endtask

  task automatic rx_diff(input int seed, input bit flip, output int bad);
    bad = 0;
    for (int a = 0; a < 64; a++) begin
      @(negedge clk);
      rd_addr = 6'(a);
      #1;
      if (rx_rd_data !== mb(seed, flip, a)) bad++;
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    bit pl, po;
    int tb, rb;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1 pulse", trace_chg, 0);
    check("R1 tx_byte", tx_byte, 0);
    rx_diff(0, 0, rb);
    check("R1 rx buffer zero", rb, 0);
    rd_addr = 6'd40; #1;
    check("R1 tx buffer zero", tx_rd_data, 0);

    for (int a = 0; a < 64; a++) begin
      @(negedge clk); wr_en = 1'b1; wr_addr = 6'(a); wr_data = tx_pat(a);
    end
    @(negedge clk); wr_en = 1'b0; rd_addr = 6'd0; #1;
    check("R5 read entry 0", tx_rd_data, tx_pat(0));
    rd_addr = 6'd63; #1;
    check("R5 read entry 63", tx_rd_data, tx_pat(63));
    check("R2 first tx byte", tx_byte, tx_pat(0));

    // R3: transmit disabled for the first 10 frames of an all-zero message
    send_msg(0, 0, 5'd0, 99, 99, 10, pl, po, tb);
    check("R3 tx off then resume", tb, 0);
    check("R3 no pulse", pl | po, 0);

    for (int r = 0; r < 20; r++) begin
      send_msg(TBL[r][23:16], TBL[r][15], TBL[r][14:10], 0, 63, 0, pl, po, tb);
      check($sformatf("R8 pulse at end, row %0d", r), pl, TBL[r][9]);
      check($sformatf("R9 no mid-message pulse, row %0d", r), po, 0);
      check($sformatf("R2 R4 tx stream, row %0d", r), tb, 0);
      rx_diff(TBL[r][8:1], TBL[r][0], rb);
      check($sformatf("R6 R7 R10 rx contents, row %0d", r), rb, 0);
    end

    // R10: defect on frames 5..9 of the third D message spoils it
    send_msg(4, 0, 5'd0, 99, 99, 0, pl, po, tb);
    send_msg(4, 0, 5'd0, 99, 99, 0, pl, po, tb);
    send_msg(4, 0, 5'b01010, 5, 9, 0, pl, po, tb);
    check("R10 defected message no pulse", pl | po, 0);
    check("R4 tx under defect", tb, 0);
    send_msg(4, 0, 5'd0, 99, 99, 0, pl, po, tb);
    send_msg(4, 0, 5'd0, 99, 99, 0, pl, po, tb);
    check("R10 two clean messages not enough", pl | po, 0);
    rx_diff(3, 0, rb);
    check("R10 rx still held", rb, 0);
    send_msg(4, 0, 5'd0, 99, 99, 0, pl, po, tb);
    check("R10 third clean message pulses", pl, 1);
    @(posedge clk); #1;
    check("R8 pulse lasts one cycle", trace_chg, 0);
    rx_diff(4, 0, rb);
    check("R7 rx holds new message", rb, 0);

    summary();
  end
endmodule